// File: doc/BRIEF.md
# Dual A/D Channel Sequencer

This block drives two four-input analog-to-digital converter units. Unit 0 serves inputs 0 to 3 and unit 1 serves inputs 4 to 7. Each unit has its own configuration register. That register holds a channel code, a sequencing mode and a run bit. From these settings the block produces the channel number to convert and a one-cycle start-of-conversion strobe for each converter. Each converter answers with a one-cycle done pulse, and the sequencer then moves to the next channel, wraps back to the first, or stops.

A shared 16-bit register carries a single writable bit, the dual-start bit. Setting it launches both units in the same cycle, and each unit uses its own settings. The bit then stays set until every selected channel on both units has been converted. Clearing a run bit, or clearing the dual-start bit, lets the conversion in progress finish and then returns the unit to idle. A standby input wipes the shared register.

Software reaches the registers through a simple write strobe with address and data, and through a combinational read port. The analog conversion, the result storage and the interrupts are handled elsewhere.

Top module: `adseq_ctrl`

## Requirements
- R1: In single mode (mode field bits [5:4] = 00), channel code n in bits [1:0] converts only input base+n, where base is 0 for unit 0 (address 0) and 4 for unit 1 (address 1). The strobe is issued exactly once, and the run bit (bit 8) reads 0 once it is done.
- R2: In multi mode (mode 01), code n converts inputs base, base+1, ..., base+n in ascending order, one strobe each. The run bit then clears by itself.
- R3: In scan mode (mode 10), after input base+n the unit restarts at input base. The run bit stays 1 until software writes it 0.
- R4: Writes to the code and mode fields are ignored while the unit's run bit is 1 or the unit is busy. Read-back shows the old values.
- R5: The shared register at address 2 reads bits 14 to 0 as 0 whatever was written. Only bit 15 can hold a 1.
- R6: The shared register reads 0x0000 after reset and after any cycle in which standby_i is high.
- R7: Writing 1 to shared bit 15 while both units are idle raises the strobe of both units in the same cycle, the cycle right after the write edge.
- R8: Shared bit 15 reads 1 while either unit is still working through a dual-start sequence. It reads 0 from the cycle in which the last unit goes idle.
- R9: Clearing the run bit, clearing shared bit 15, or raising standby lets the current conversion end. No further strobe follows, and busy drops on that conversion's done pulse.
- R10: Each unit advances only on its own done pulse. A done pulse to an idle unit produces no strobe.
- R11: The strobe lasts one cycle per channel and only occurs while the unit's busy flag is high, with cur_ch_o giving the channel being started.
- R12: After reset both units are idle, no strobe is high, and all registers read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| standby_i | input | 1 | Clears the shared register |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 unit 0, 1 unit 1, 2 shared |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 2 | Read address, same map |
| rd_data_o | output | 16 | Read data, combinational |
| done_i | input | 2 | Per-unit conversion-done pulse |
| soc_o | output | 2 | Per-unit start-of-conversion strobe |
| busy_o | output | 2 | Per-unit sequence-active flag |
| cur_ch_o | output | 6 | Per-unit 3-bit channel number, unit 0 in bits [2:0] |

## Verification
The bench builds the block with its default values: two units of four inputs each, a 16-bit register width and 3-bit channel numbers. These values give the two unit bases, 0 and 4, and the top shared bit at position 15. They also keep the longest multi sequence to four conversions, so every channel code, the wrap in scan mode, and a dual start in which one unit ends well before the other all fit in short runs. Per-unit stub latencies are varied so that the done pulses of the two units arrive out of step.

// File: rtl/adseq_pkg.sv
package adseq_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_MULTI  = 2'b01,
    MODE_SCAN   = 2'b10
  } seq_mode_e;

  localparam int CFG_MODE_LSB  = 4;
  localparam int CFG_START_BIT = 8;

endpackage

// File: rtl/adseq_unit.sv
module adseq_unit
  import adseq_pkg::*;
#(
  parameter int IN_PER_UNIT = 4,
  parameter int CH_W        = 3,
  parameter int REG_W       = 16,
  parameter int BASE        = 0,
  localparam int SEL_W      = (IN_PER_UNIT > 1) ? $clog2(IN_PER_UNIT) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [SEL_W-1:0] cfg_sel_i,
  input  logic [1:0]       cfg_mode_i,
  input  logic             cfg_start_i,
  input  logic             sim_launch_i,
  input  logic             sim_run_i,
  input  logic             done_i,
  output logic [REG_W-1:0] cfg_rd_o,
  output logic             busy_o,
  output logic             soc_o,
  output logic [CH_W-1:0]  cur_ch_o,
  output logic             launch_o,
  output logic             fin_o,
  output logic             run_req_o,
  output logic [SEL_W-1:0] sel_o
);

  logic             start_q, busy_q, soc_q;
  logic [SEL_W-1:0] sel_q, ofs_q;
  logic [1:0]       mode_q;

  // first offset of a sequence: single mode jumps to the code, others begin at 0
  function automatic logic [SEL_W-1:0] first_ofs(input logic [1:0] m,
                                                 input logic [SEL_W-1:0] s);
    return (m == MODE_SINGLE) ? s : '0;
  endfunction

  // every mode ends its pass at the offset named by the code
  function automatic logic is_last(input logic [SEL_W-1:0] o,
                                   input logic [SEL_W-1:0] s);
    return o == s;
  endfunction

  logic             cfg_open, step, abort_ev, wrap_ev, adv_ev, at_last, scan_m;
  logic [SEL_W-1:0] eff_sel;
  logic [1:0]       eff_mode;

  assign cfg_open  = ~busy_q & ~start_q;
  assign eff_sel   = (cfg_we_i & cfg_open) ? cfg_sel_i  : sel_q;
  assign eff_mode  = (cfg_we_i & cfg_open) ? cfg_mode_i : mode_q;
  assign launch_o  = ~busy_q & ((cfg_we_i & cfg_start_i) | sim_launch_i);
  assign run_req_o = start_q | sim_run_i;
  assign scan_m    = (mode_q == MODE_SCAN);
  assign at_last   = is_last(ofs_q, sel_q);
  assign step      = busy_q & done_i;
  assign abort_ev  = step & ~run_req_o;
  assign fin_o     = step & run_req_o & at_last & ~scan_m;
  assign wrap_ev   = step & run_req_o & at_last & scan_m;
  assign adv_ev    = step & run_req_o & ~at_last;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      busy_q  <= 1'b0;
      soc_q   <= 1'b0;
      sel_q   <= '0;
      ofs_q   <= '0;
      mode_q  <= 2'b00;
    end else begin
      soc_q <= launch_o | wrap_ev | adv_ev;
      if (cfg_we_i && cfg_open) begin
        sel_q  <= cfg_sel_i;
        mode_q <= cfg_mode_i;
      end
      if (cfg_we_i)   start_q <= cfg_start_i;
      else if (fin_o) start_q <= 1'b0;
      if (launch_o) begin
        busy_q <= 1'b1;
        ofs_q  <= first_ofs(eff_mode, eff_sel);
      end else if (abort_ev || fin_o) begin
        busy_q <= 1'b0;
      end else if (wrap_ev) begin
        ofs_q <= '0;
      end else if (adv_ev) begin
        ofs_q <= ofs_q + 1'b1;
      end
    end
  end

  always_comb begin
    cfg_rd_o                            = '0;
    cfg_rd_o[SEL_W-1:0]                 = sel_q;
    cfg_rd_o[CFG_MODE_LSB +: 2]         = mode_q;
    cfg_rd_o[CFG_START_BIT]             = start_q;
  end

  assign busy_o   = busy_q;
  assign soc_o    = soc_q;
  assign sel_o    = sel_q;
  assign cur_ch_o = CH_W'(BASE) + CH_W'(ofs_q);

endmodule

// File: rtl/adseq_shared.sv
module adseq_shared #(
  parameter int NUM_UNITS = 2,
  parameter int REG_W     = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 standby_i,
  input  logic                 we_i,
  input  logic                 wbit_i,
  input  logic [NUM_UNITS-1:0] busy_i,
  input  logic [NUM_UNITS-1:0] fin_i,
  output logic                 sim_o,
  output logic                 launch_o,
  output logic                 clear_wr_o,
  output logic [REG_W-1:0]     rd_o
);

  logic                 sim_q, set_req;
  logic [NUM_UNITS-1:0] pend_q, pend_nxt;

  assign set_req    = we_i & wbit_i & ~sim_q & ~(|busy_i);
  assign clear_wr_o = we_i & ~wbit_i;
  assign launch_o   = set_req & ~standby_i;
  assign pend_nxt   = pend_q & ~fin_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni || standby_i || clear_wr_o) begin
      sim_q  <= 1'b0;
      pend_q <= '0;
    end else if (set_req) begin
      sim_q  <= 1'b1;
      pend_q <= '1;
    end else if (sim_q) begin
      pend_q <= pend_nxt;
      if (pend_nxt == '0) sim_q <= 1'b0;
    end
  end

  assign sim_o = sim_q;
  assign rd_o  = {sim_q, {(REG_W-1){1'b0}}};

endmodule

// File: rtl/adseq_ctrl.sv
module adseq_ctrl
  import adseq_pkg::*;
#(
  parameter int NUM_UNITS   = 2,
  parameter int IN_PER_UNIT = 4,
  parameter int REG_W       = 16,
  localparam int CH_W       = $clog2(NUM_UNITS * IN_PER_UNIT),
  localparam int ADDR_W     = $clog2(NUM_UNITS + 1),
  localparam int SEL_W      = (IN_PER_UNIT > 1) ? $clog2(IN_PER_UNIT) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      standby_i,
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         wr_addr_i,
  input  logic [REG_W-1:0]          wr_data_i,
  input  logic [ADDR_W-1:0]         rd_addr_i,
  output logic [REG_W-1:0]          rd_data_o,
  input  logic [NUM_UNITS-1:0]      done_i,
  output logic [NUM_UNITS-1:0]      soc_o,
  output logic [NUM_UNITS-1:0]      busy_o,
  output logic [NUM_UNITS*CH_W-1:0] cur_ch_o
);

  logic                       sim_run, sim_launch, sim_clear_wr, shr_we;
  logic [NUM_UNITS-1:0]       unit_we, unit_launch, unit_fin, unit_run;
  logic [NUM_UNITS*SEL_W-1:0] unit_sel;
  logic [REG_W-1:0]           unit_rd [NUM_UNITS];
  logic [REG_W-1:0]           shr_rd;
  logic                       unused_wr;

  assign unused_wr = ^wr_data_i;
  assign shr_we    = wr_en_i & (wr_addr_i == ADDR_W'(NUM_UNITS));

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    assign unit_we[u] = wr_en_i & (wr_addr_i == ADDR_W'(u));

    adseq_unit #(
      .IN_PER_UNIT (IN_PER_UNIT),
      .CH_W        (CH_W),
      .REG_W       (REG_W),
      .BASE        (u * IN_PER_UNIT)
    ) u_unit (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .cfg_we_i     (unit_we[u]),
      .cfg_sel_i    (wr_data_i[SEL_W-1:0]),
      .cfg_mode_i   (wr_data_i[CFG_MODE_LSB +: 2]),
      .cfg_start_i  (wr_data_i[CFG_START_BIT]),
      .sim_launch_i (sim_launch),
      .sim_run_i    (sim_run),
      .done_i       (done_i[u]),
      .cfg_rd_o     (unit_rd[u]),
      .busy_o       (busy_o[u]),
      .soc_o        (soc_o[u]),
      .cur_ch_o     (cur_ch_o[u*CH_W +: CH_W]),
      .launch_o     (unit_launch[u]),
      .fin_o        (unit_fin[u]),
      .run_req_o    (unit_run[u]),
      .sel_o        (unit_sel[u*SEL_W +: SEL_W])
    );
  end

  adseq_shared #(
    .NUM_UNITS (NUM_UNITS),
    .REG_W     (REG_W)
  ) u_shared (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .standby_i  (standby_i),
    .we_i       (shr_we),
    .wbit_i     (wr_data_i[REG_W-1]),
    .busy_i     (busy_o),
    .fin_i      (unit_fin),
    .sim_o      (sim_run),
    .launch_o   (sim_launch),
    .clear_wr_o (sim_clear_wr),
    .rd_o       (shr_rd)
  );

  always_comb begin
    rd_data_o = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (rd_addr_i == ADDR_W'(u)) rd_data_o = unit_rd[u];
    end
    if (rd_addr_i == ADDR_W'(NUM_UNITS)) rd_data_o = shr_rd;
  end

endmodule

// File: rtl/adseq_ctrl_chk.sv
module adseq_ctrl_chk #(
  parameter int NUM_UNITS   = 2,
  parameter int IN_PER_UNIT = 4,
  parameter int REG_W       = 16,
  localparam int ADDR_W     = $clog2(NUM_UNITS + 1),
  localparam int SEL_W      = (IN_PER_UNIT > 1) ? $clog2(IN_PER_UNIT) : 1
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       standby_i,
  input logic [ADDR_W-1:0]          rd_addr_i,
  input logic [REG_W-1:0]           rd_data_o,
  input logic [NUM_UNITS-1:0]       done_i,
  input logic [NUM_UNITS-1:0]       soc_o,
  input logic [NUM_UNITS-1:0]       busy_o,
  input logic                       sim_run,
  input logic                       sim_launch,
  input logic                       sim_clear_wr,
  input logic [NUM_UNITS-1:0]       unit_launch,
  input logic [NUM_UNITS-1:0]       unit_run,
  input logic [NUM_UNITS*SEL_W-1:0] unit_sel
);

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_chk
    // R11
    soc_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      soc_o[u] |-> busy_o[u]);

    // R10
    idle_done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_o[u] && done_i[u] && !unit_launch[u]) |=> !soc_o[u]);

    // R9
    abort_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o[u] && done_i[u] && !unit_run[u]) |=> (!busy_o[u] && !soc_o[u]));

    // R4
    cfg_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o[u] && $past(busy_o[u])) |-> $stable(unit_sel[u*SEL_W +: SEL_W]));
  end

  // R7
  dual_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sim_launch |=> (soc_o == '1));

  // R8
  dual_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sim_run) |-> (busy_o == '0 || $past(standby_i) || $past(sim_clear_wr)));

  // R5
  shared_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == ADDR_W'(NUM_UNITS)) |-> (rd_data_o[REG_W-2:0] == '0));

  // R6
  standby_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |=> !sim_run);

endmodule

bind adseq_ctrl adseq_ctrl_chk #(
  .NUM_UNITS   (NUM_UNITS),
  .IN_PER_UNIT (IN_PER_UNIT),
  .REG_W       (REG_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .standby_i    (standby_i),
  .rd_addr_i    (rd_addr_i),
  .rd_data_o    (rd_data_o),
  .done_i       (done_i),
  .soc_o        (soc_o),
  .busy_o       (busy_o),
  .sim_run      (sim_run),
  .sim_launch   (sim_launch),
  .sim_clear_wr (sim_clear_wr),
  .unit_launch  (unit_launch),
  .unit_run     (unit_run),
  .unit_sel     (unit_sel)
);

// File: tb/adseq_ctrl_test.sv
module adseq_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int SINGLE = 0, MULTI = 1, SCAN = 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        standby_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [1:0]  rd_addr_i = '0;
  logic [15:0] rd_data_o;
  logic [1:0]  done_i = '0;
  logic [1:0]  soc_o, busy_o;
  logic [5:0]  cur_ch_o;

  int n_vec = 0, n_bad = 0;
  int q0[$];
  int q1[$];
  int soc_cnt[2] = '{0, 0};
  int lat[2] = '{3, 5};
  bit stub_en = 1'b1;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  adseq_ctrl uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .standby_i(standby_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .done_i(done_i), .soc_o(soc_o), .busy_o(busy_o), .cur_ch_o(cur_ch_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  function automatic logic [15:0] cfg(input int sel, input int mode, input int run);
    return 16'((run << 8) | (mode << 4) | sel);
  endfunction

  task automatic wr(input int addr, input logic [15:0] data);
    wr_en_i   = 1'b1;
    wr_addr_i = 2'(addr);
    wr_data_i = data;
    @(negedge clk_i);
    wr_en_i   = 1'b0;
    #1;
  endtask

  task automatic rd(input int addr, output logic [15:0] data);
    rd_addr_i = 2'(addr);
    #1;
    data = rd_data_o;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy_o != 2'b00; i++) @(negedge clk_i);
    #2;
  endtask

  task automatic stub(input int u);
    forever begin
      @(negedge clk_i);
      while (stub_en && soc_o[u]) begin
        repeat (lat[u] - 1) @(negedge clk_i);
        done_i[u] = 1'b1;
        @(negedge clk_i);
        done_i[u] = 1'b0;
      end
    end
  endtask

  initial begin
    fork
      stub(0);
      stub(1);
    join_none
  end

  // scoreboard monitor: every strobe must carry the next expected channel (R1 R2 R3 R11)
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni) begin
        for (int u = 0; u < 2; u++) begin
          if (soc_o[u]) begin
            int ch, exp;
            ch = int'(cur_ch_o[u*3 +: 3]);
            soc_cnt[u]++;
            if ((u == 0 && q0.size() == 0) || (u == 1 && q1.size() == 0)) begin
              check(1'b0, "R11", "unexpected strobe channel", ch, -1);
            end else begin
              exp = (u == 0) ? q0.pop_front() : q1.pop_front();
              check(ch == exp, "R2", "strobe channel order", ch, exp);
            end
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "R11", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic [15:0] d;
    int base0, base1;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    // R12 reset state
    check(busy_o == 2'b00, "R12", "busy after reset", busy_o, 0);
    check(soc_o == 2'b00, "R12", "strobe after reset", soc_o, 0);
    for (int a = 0; a < 3; a++) begin
      rd(a, d);
      check(d == 16'h0, "R12", "register after reset", d, 0);
    end

    // R5 low bits of the shared register never hold
    wr(2, 16'h7FFF);
    rd(2, d);
    check(d == 16'h0000, "R5", "shared low bits", d, 0);
    check(busy_o == 2'b00, "R5", "no launch from low bits", busy_o, 0);

    // R1 single mode, unit 0 code 2 -> input 2
    q0.push_back(2);
    base0 = soc_cnt[0];
    wr(0, cfg(2, SINGLE, 1));
    check(busy_o[0] == 1'b1, "R11", "busy at launch", busy_o[0], 1);
    rd(0, d);
    check(d[8] == 1'b1, "R1", "run bit while converting", d[8], 1);
    wait_idle();
    rd(0, d);
    check(d == cfg(2, SINGLE, 0), "R1", "run bit self-clear", d, cfg(2, SINGLE, 0));
    check(soc_cnt[0] - base0 == 1, "R1", "single strobe count", soc_cnt[0] - base0, 1);

    // R1 single mode, unit 1 code 3 -> input 7
    q1.push_back(7);
    base1 = soc_cnt[1];
    wr(1, cfg(3, SINGLE, 1));
    wait_idle();
    check(soc_cnt[1] - base1 == 1, "R1", "unit1 single strobe count", soc_cnt[1] - base1, 1);

    // R2 multi mode, unit 1 code 1 -> 4,5
    q1.push_back(4); q1.push_back(5);
    base1 = soc_cnt[1];
    wr(1, cfg(1, MULTI, 1));
    wait_idle();
    rd(1, d);
    check(d == cfg(1, MULTI, 0), "R2", "unit1 run bit self-clear", d, cfg(1, MULTI, 0));
    check(soc_cnt[1] - base1 == 2, "R2", "unit1 multi count", soc_cnt[1] - base1, 2);

    // R2 multi mode, unit 0 code 3 -> 0..3, with R4 locked config
    for (int c = 0; c < 4; c++) q0.push_back(c);
    base0 = soc_cnt[0];
    wr(0, cfg(3, MULTI, 1));
    wr(0, cfg(0, SINGLE, 1));
    rd(0, d);
    check(d == cfg(3, MULTI, 1), "R4", "config write while busy", d, cfg(3, MULTI, 1));
    wait_idle();
    check(soc_cnt[0] - base0 == 4, "R2", "unit0 multi count", soc_cnt[0] - base0, 4);
    rd(0, d);
    check(d == cfg(3, MULTI, 0), "R2", "unit0 run bit self-clear", d, cfg(3, MULTI, 0));

    // R7 R8 dual start: unit 0 multi 0..3 fast, unit 1 single input 6 slow
    lat[0] = 2; lat[1] = 20;
    wr(1, cfg(2, SINGLE, 0));
    for (int c = 0; c < 4; c++) q0.push_back(c);
    q1.push_back(6);
    wr(2, 16'h80FF);
    check(soc_o == 2'b11, "R7", "both strobes together", soc_o, 3);
    rd(2, d);
    check(d == 16'h8000, "R5", "shared read during dual start", d, 16'h8000);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk_i);
      rd(2, d);
      if (busy_o != 2'b00) begin
        if (d[15] != 1'b1) check(1'b0, "R8", "dual bit while busy", d, 16'h8000);
      end else begin
        check(d == 16'h0000, "R8", "dual bit after both finish", d, 0);
        break;
      end
    end
    check(busy_o == 2'b00, "R8", "both units idle", busy_o, 0);

    // R3 scan wraps, R9 abort after conversion in progress
    lat[0] = 3;
    for (int i = 0; i < 5; i++) q0.push_back(i % 2);
    base0 = soc_cnt[0];
    wr(0, cfg(1, SCAN, 1));
    for (int i = 0; i < 500 && soc_cnt[0] - base0 < 5; i++) begin
      @(negedge clk_i);
      #2;
    end
    rd(0, d);
    check(d[8] == 1'b1, "R3", "run bit held in scan", d[8], 1);
    wr(0, cfg(1, SCAN, 0));
    wait_idle();
    check(soc_cnt[0] - base0 == 5, "R9", "no strobe after abort", soc_cnt[0] - base0, 5);

    // R10 done to idle units
    stub_en = 1'b0;
    base0 = soc_cnt[0]; base1 = soc_cnt[1];
    done_i = 2'b11;
    @(negedge clk_i);
    done_i = 2'b00;
    #1;
    check(soc_o == 2'b00, "R10", "no strobe from idle done", soc_o, 0);
    @(negedge clk_i);
    #2;
    check(busy_o == 2'b00, "R10", "idle units stay idle", busy_o, 0);
    check(soc_cnt[0] + soc_cnt[1] == base0 + base1, "R10", "strobe count unchanged",
          soc_cnt[0] + soc_cnt[1], base0 + base1);
    stub_en = 1'b1;

    // R6 standby wipes the shared bit, R9 both units stop after current
    lat[0] = 20; lat[1] = 20;
    wr(0, cfg(3, MULTI, 0));
    wr(1, cfg(3, MULTI, 0));
    q0.push_back(0); q1.push_back(4);
    base0 = soc_cnt[0]; base1 = soc_cnt[1];
    wr(2, 16'h8000);
    rd(2, d);
    check(d == 16'h8000, "R8", "dual bit set", d, 16'h8000);
    standby_i = 1'b1;
    @(negedge clk_i);
    standby_i = 1'b0;
    rd(2, d);
    check(d == 16'h0000, "R6", "standby clears shared", d, 0);
    wait_idle();
    check(soc_cnt[0] - base0 == 1, "R9", "unit0 stops after standby", soc_cnt[0] - base0, 1);
    check(soc_cnt[1] - base1 == 1, "R9", "unit1 stops after standby", soc_cnt[1] - base1, 1);

    check(q0.size() == 0, "R2", "unit0 expected channels left", q0.size(), 0);
    check(q1.size() == 0, "R2", "unit1 expected channels left", q1.size(), 0);
    repeat (2) @(negedge clk_i);
    finish_run();
  end

endmodule